// File: doc/BRIEF.md
# Four-Phase External Memory Cycle Controller

This block connects a processor's internal load/store path to an asynchronous external memory bus. Each access it accepts is run as a fixed sequence of four clock states: T1 for address and control setup, T2 for write-data setup, T3 for the transfer itself, and T4 for hold. The chip enable is active-low. It is low from T1 through T4 and high between accesses. The address stays stable for the whole of that window. The bus carries two 8-bit byte lanes. A 16-bit access uses both lanes. An 8-bit access uses the lane picked by address bit 0.

Slow devices stretch an access through a wait input. The controller samples that input once, at the clock edge that closes T1. If it was high there, the controller places wait states between T2 and T3, and keeps adding them until it samples the input low. A companion module, `memcyc_waitgen`, builds the wait signal from the chip enable alone. It is a chain of flops that is preset while the chip enable is high and shifts out the preset once the enable goes low. A select input picks the tap that produces the wait signal, and the chosen tap sets the number of wait states.

Requests arrive on a valid/ready channel. The requester holds the request fields steady while `req_valid` is high. A transfer happens on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the bus is idle, so a request is held off for the full length of the access in progress. The result comes back as a one-cycle `rsp_valid` pulse in T4. That pulse has no back-pressure, so the requester must take it in that cycle.

Top module: `memcyc_ctrl`

## Requirements
- R1: While reset is asserted, `mem_ce_n` is 1, `mem_wr_n` is 2'b11, `mem_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is high exactly when the bus is idle. A request taken on an edge starts T1 in the next cycle. `mem_ce_n` is low from T1 through T4 and goes high in the cycle after T4, so back-to-back accesses always have at least one idle cycle between them.
- R3: `mem_addr` equals the accepted request address in every cycle from T1 through T4.
- R4: The controller samples `mem_wait` only at the edge that ends T1. If it was low there, the access takes exactly 4 cycles, whatever `mem_wait` does later.
- R5: If `mem_wait` was high at the end of T1, the controller inserts wait states after T2. It adds one for each edge at which it still samples `mem_wait` high, starting with the edge that ends T2 itself. This gives at least one wait state.
- R6: On a write, the byte strobes are low in T2, in every wait state and in T3, and high in T1 and T4. A 16-bit write (`req_wide`=1) pulls both strobes low. An 8-bit write pulls only the strobe selected by address bit 0: bit 0 = 0 gives `mem_wr_n`=2'b10, and bit 0 = 1 gives 2'b01. Bit 0 of `mem_wr_n` controls lane `mem_dout[7:0]`.
- R7: On a read, both strobes stay high for the whole access.
- R8: `mem_oe` is high from T2 through T4 on writes, and low in every cycle of a read. While it is high, `mem_dout` carries `req_wdata` for a 16-bit write. For an 8-bit write it carries `req_wdata[7:0]` on both lanes.
- R9: Read data is the value on `mem_din` at the edge that ends T3. In T4, `rsp_rdata` holds that whole value for a 16-bit read. For an 8-bit read it holds the lane picked by address bit 0 (bit 0 = 1 selects `mem_din[15:8]`), zero-extended. For a write, `rsp_rdata` is zero.
- R10: `rsp_valid` is high for exactly one cycle per access, in T4, for both reads and writes.
- R11: With select value N > 0, `memcyc_waitgen` drives its output high whenever the chip enable has been high at the previous edge. It keeps the output high through the first N+1 cycles of an access (T1 counts as the first) and low afterwards, which yields N wait states. With N = 0 the output is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid (bus idle) |
| req_addr | input | AW | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_wdata | input | 2*LANE_W | Write data (low byte used for 8-bit writes) |
| rsp_valid | output | 1 | One-cycle done pulse in T4 |
| rsp_rdata | output | 2*LANE_W | Read result, valid with rsp_valid |
| mem_addr | output | AW | External address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_wr_n | output | 2 | Active-low byte write strobes, bit i for lane i |
| mem_oe | output | 1 | Data-out enable for the external data bus |
| mem_dout | output | 2*LANE_W | Data driven onto the external bus |
| mem_din | input | 2*LANE_W | Data read from the external bus |
| mem_wait | input | 1 | Wait request from the external device |

## Verification
Accesses run with every combination of read or write, 16-bit or 8-bit width, and both values of address bit 0. This separates the strobe pattern, the lane steering and the zero-extension. The wait input comes either from the companion generator, with taps 0, 1, 2 and several larger ones, or straight from the bench. The direct drive checks two cases: wait low at the end of T1 but high later, which must add nothing, and wait high in T1 then dropped at once, which must still give one wait state. Each pattern checks the stretch length cycle by cycle. The data bus is given a new random value every cycle, so read data captured one cycle early or late shows up as a mismatch.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

  // Bus phases of one external access.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/memcyc_seq.sv
// Phase sequencer: walks IDLE -> T1 -> T2 -> [TW...] -> T3 -> T4 -> IDLE.
module memcyc_seq
  import memcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   mem_wait,
  output phase_e phase,
  output logic   load,
  output logic   capture
);

  phase_e phase_q;
  logic   wait_armed_q;

  assign phase   = phase_q;
  assign load    = (phase_q == PH_IDLE) && req_valid;
  assign capture = (phase_q == PH_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      wait_armed_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_valid) phase_q <= PH_T1;
        PH_T1: begin
          wait_armed_q <= mem_wait;     // only sample point for a new stretch
          phase_q      <= PH_T2;
        end
        PH_T2:   phase_q <= wait_armed_q ? PH_TW : PH_T3;
        PH_TW:   if (!mem_wait) phase_q <= PH_T3;
        PH_T3:   phase_q <= PH_T4;
        PH_T4:   phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/memcyc_reqreg.sv
// Holds the accepted request for the whole access and captures read data.
module memcyc_reqreg #(
  parameter  int AW     = 16,
  parameter  int LANE_W = 8,
  localparam int DW     = 2 * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic          in_wide,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] addr_q,
  output logic          write_q,
  output logic          wide_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= in_addr;
      write_q <= in_write;
      wide_q  <= in_wide;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_din;
  end

endmodule

// File: rtl/memcyc_lanes.sv
// Byte-lane steering: strobe selection, write replication, read alignment.
module memcyc_lanes
  import memcyc_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int DW     = NUM_LANES * LANE_W
) (
  input  logic                 write,
  input  logic                 wide,
  input  logic                 a0,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        rdq,
  output logic [NUM_LANES-1:0] lane_sel,
  output logic [DW-1:0]        dout,
  output logic [DW-1:0]        rdata
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_sel[l]             = wide | (a0 == 1'(l));
    assign dout[l*LANE_W +: LANE_W] = wide ? wdata[l*LANE_W +: LANE_W]
                                           : wdata[LANE_W-1:0];
  end

  logic [LANE_W-1:0] narrow;
  assign narrow = a0 ? rdq[DW-1:LANE_W] : rdq[LANE_W-1:0];

  always_comb begin
    if (write)     rdata = '0;
    else if (wide) rdata = rdq;
    else           rdata = {{(DW-LANE_W){1'b0}}, narrow};
  end

endmodule

// File: rtl/memcyc_waitgen.sv
// Companion wait generator: a flop chain preset while chip enable is high,
// shifting zeros once it goes low. The tap picked by sel is the wait output.
module memcyc_waitgen #(
  parameter  int MAX_WAIT = 7,
  localparam int SW       = $clog2(MAX_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [SW-1:0] sel,
  output logic          wait_o
);

  logic [MAX_WAIT:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chain_q <= '1;
    else if (ce_n) chain_q <= '1;
    else           chain_q <= {chain_q[MAX_WAIT-1:0], 1'b0};
  end

  assign wait_o = (sel == '0) ? 1'b0 : chain_q[sel];

endmodule

// File: rtl/memcyc_ctrl.sv
// Top: four-phase external memory cycle controller.
module memcyc_ctrl
  import memcyc_pkg::*;
#(
  parameter  int AW     = 16,
  parameter  int LANE_W = 8,
  localparam int DW     = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_ce_n,
  output logic [NUM_LANES-1:0] mem_wr_n,
  output logic                 mem_oe,
  output logic [DW-1:0]        mem_dout,
  input  logic [DW-1:0]        mem_din,
  input  logic                 mem_wait
);

  phase_e                phase;
  logic                  load, capture;
  logic [AW-1:0]         addr_q;
  logic                  write_q, wide_q;
  logic [DW-1:0]         wdata_q, rdata_q;
  logic [NUM_LANES-1:0]  lane_sel;
  logic                  strobe_ph, drive_ph;

  memcyc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_wait  (mem_wait),
    .phase     (phase),
    .load      (load),
    .capture   (capture)
  );

  memcyc_reqreg #(.AW(AW), .LANE_W(LANE_W)) u_reqreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .capture  (capture),
    .in_addr  (req_addr),
    .in_write (req_write),
    .in_wide  (req_wide),
    .in_wdata (req_wdata),
    .bus_din  (mem_din),
    .addr_q   (addr_q),
    .write_q  (write_q),
    .wide_q   (wide_q),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata_q)
  );

  memcyc_lanes #(.LANE_W(LANE_W)) u_lanes (
    .write    (write_q),
    .wide     (wide_q),
    .a0       (addr_q[0]),
    .wdata    (wdata_q),
    .rdq      (rdata_q),
    .lane_sel (lane_sel),
    .dout     (mem_dout),
    .rdata    (rsp_rdata)
  );

  assign strobe_ph = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign drive_ph  = strobe_ph || (phase == PH_T4);

  assign req_ready = (phase == PH_IDLE);
  assign mem_ce_n  = (phase == PH_IDLE);
  assign mem_addr  = addr_q;
  assign mem_wr_n  = ~(lane_sel & {NUM_LANES{write_q & strobe_ph}});
  assign mem_oe    = write_q & drive_ph;
  assign rsp_valid = (phase == PH_T4);

endmodule

// File: rtl/memcyc_ctrl_chk.sv
// Protocol checker bound to memcyc_ctrl.
module memcyc_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_ce_n,
  input logic [1:0]    mem_wr_n,
  input logic          mem_oe,
  input logic [AW-1:0] mem_addr,
  input logic          rsp_valid
);

  // R2: an accepted request opens the bus in the next cycle.
  p_accept_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_ce_n && !req_ready));

  // R2: never ready while the bus is enabled.
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  // R3: address held steady across the enabled window.
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R6: no strobe in T1.
  p_no_strobe_t1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (mem_wr_n == 2'b11));

  // R8: a strobe only with data driven on the bus.
  p_strobe_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n != 2'b11) |-> (mem_oe && !mem_ce_n));

  // R10: done is a single-cycle pulse that closes the access.
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && mem_ce_n));

  // R10: done only while the bus is enabled, never with a strobe.
  p_done_in_t4_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_ce_n && mem_wr_n == 2'b11));

endmodule

bind memcyc_ctrl memcyc_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_ce_n  (mem_ce_n),
  .mem_wr_n  (mem_wr_n),
  .mem_oe    (mem_oe),
  .mem_addr  (mem_addr),
  .rsp_valid (rsp_valid)
);

// File: tb/memcyc_ctrl_tb.sv
module memcyc_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int MAXW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n;
  logic [1:0]  mem_wr_n;
  logic        mem_oe;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = '0;
  logic        mem_wait;
  logic        use_gen = 1'b1;
  logic        tb_wait = 1'b0;
  logic [2:0]  wsel = '0;
  logic        gen_wait;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_wait = use_gen ? gen_wait : tb_wait;

  memcyc_ctrl #(.AW(AW), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_wr_n(mem_wr_n),
    .mem_oe(mem_oe), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_wait(mem_wait)
  );

  memcyc_waitgen #(.MAX_WAIT(MAXW)) u_wgen (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .sel(wsel), .wait_o(gen_wait)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_wrn(input logic wr, input logic wide,
                                         input logic a0, input int k, input int w);
    if (!wr || k < 1 || k > 2 + w) return 2'b11;
    if (wide) return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] exp_dout(input logic wide, input logic [15:0] d);
    return wide ? d : {d[7:0], d[7:0]};
  endfunction

  function automatic logic [15:0] exp_rd(input logic wr, input logic wide,
                                         input logic a0, input logic [15:0] d);
    if (wr)   return 16'h0000;
    if (wide) return d;
    return a0 ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
  endfunction

  function automatic int exp_waits(input bit gen, input int sel, input bit t1w,
                                   input int late);
    if (gen) return sel;
    if (!t1w) return 0;
    return (late < 1) ? 1 : late;
  endfunction

  // Called at a negedge while the bus is idle; returns at the negedge of the
  // idle cycle that follows T4.
  task automatic run_access(input logic wr, input logic wide, input logic [15:0] addr,
                            input logic [15:0] wd, input bit gen, input int sel,
                            input bit t1w, input int late);
    int w;
    logic [15:0] din_t3;
    w = exp_waits(gen, sel, t1w, late);
    din_t3 = '0;
    chk(req_ready === 1'b1 && mem_ce_n === 1'b1, "R2 idle ready", {30'd0, req_ready, mem_ce_n}, 32'd3);
    use_gen = gen; wsel = 3'(sel);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_wide = wide; req_wdata = wd;
    for (int k = 0; k <= 4 + w; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        req_addr = ~addr; req_wdata = ~wd;   // changes must not reach the bus
      end
      if (k <= 3 + w) begin
        chk(mem_ce_n === 1'b0, "R2 ce low in access", {31'd0, mem_ce_n}, 32'd0);
        chk(req_ready === 1'b0, "R2 not ready while busy", {31'd0, req_ready}, 32'd0);
        chk(mem_addr === addr, "R3 address", {16'd0, mem_addr}, {16'd0, addr});
        chk(mem_wr_n === exp_wrn(wr, wide, addr[0], k, w),
            wr ? "R6 write strobes" : "R7 read strobes",
            {30'd0, mem_wr_n}, {30'd0, exp_wrn(wr, wide, addr[0], k, w)});
        chk(mem_oe === (wr && k >= 1), "R8 data enable", {31'd0, mem_oe}, {31'd0, wr && k >= 1});
        if (wr && k >= 1)
          chk(mem_dout === exp_dout(wide, wd), "R8 write data", {16'd0, mem_dout},
              {16'd0, exp_dout(wide, wd)});
        chk(rsp_valid === (k == 3 + w), "R10 done timing", {31'd0, rsp_valid}, {31'd0, k == 3 + w});
        if (k == 3 + w)
          chk(rsp_rdata === exp_rd(wr, wide, addr[0], din_t3), "R9 read data",
              {16'd0, rsp_rdata}, {16'd0, exp_rd(wr, wide, addr[0], din_t3)});
        if (gen)
          chk(gen_wait === (sel != 0 && k <= sel), "R11 wait generator", {31'd0, gen_wait},
              {31'd0, sel != 0 && k <= sel});
      end else begin
        chk(mem_ce_n === 1'b1 && req_ready === 1'b1, w == 0 ? "R4 four-cycle access" : "R5 stretched access",
            {30'd0, mem_ce_n, req_ready}, 32'd3);
        chk(rsp_valid === 1'b0 && mem_wr_n === 2'b11 && mem_oe === 1'b0, "R10 bus quiet after T4",
            {28'd0, rsp_valid, mem_wr_n, mem_oe}, 32'd6);
      end
      tb_wait = (k == 0) ? t1w : (k <= late);
      mem_din = 16'($urandom);
      if (k == 2 + w) din_t3 = mem_din;
    end
    tb_wait = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(mem_ce_n === 1'b1, "R1 ce_n", {31'd0, mem_ce_n}, 32'd1);
    chk(mem_wr_n === 2'b11, "R1 wr_n", {30'd0, mem_wr_n}, 32'd3);
    chk(mem_oe === 1'b0 && rsp_valid === 1'b0, "R1 oe/done", {30'd0, mem_oe, rsp_valid}, 32'd0);
    chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_access(1'b0, 1'b1, 16'h1234, 16'h0000, 1'b1, 0, 1'b0, 0);  // R4 read 16, no wait
    run_access(1'b1, 1'b1, 16'h2000, 16'hBEEF, 1'b1, 0, 1'b0, 0);  // R6 write 16
    run_access(1'b1, 1'b0, 16'h3000, 16'h00A5, 1'b1, 0, 1'b0, 0);  // R6 byte lane 0
    run_access(1'b1, 1'b0, 16'h3001, 16'h005A, 1'b1, 1, 1'b0, 0);  // R6 byte lane 1, 1 wait
    run_access(1'b0, 1'b0, 16'h4001, 16'h0000, 1'b1, 2, 1'b0, 0);  // R9 read hi lane, 2 waits
    run_access(1'b0, 1'b0, 16'h4000, 16'h0000, 1'b1, 5, 1'b0, 0);  // R9 read lo lane, 5 waits
    run_access(1'b1, 1'b1, 16'h5555, 16'hC3C3, 1'b1, MAXW, 1'b0, 0); // R11 max tap
    run_access(1'b0, 1'b1, 16'h6000, 16'h0000, 1'b0, 0, 1'b0, 3);  // R4 late wait ignored
    run_access(1'b1, 1'b1, 16'h6002, 16'h1111, 1'b0, 0, 1'b1, 0);  // R5 minimum one wait
    run_access(1'b0, 1'b1, 16'h6004, 16'h0000, 1'b0, 0, 1'b1, 4);  // R5 held wait

    // Constrained random accesses
    for (int i = 0; i < 80; i++) begin
      automatic logic wr   = 1'($urandom);
      automatic logic wide = 1'($urandom);
      automatic logic [15:0] a = 16'($urandom);
      automatic logic [15:0] d = 16'($urandom);
      automatic bit gen = ($urandom % 3) != 0;
      automatic int sel = int'($urandom % (MAXW + 1));
      automatic bit t1w = 1'($urandom);
      automatic int late = int'($urandom % 6);
      run_access(wr, wide, a, d, gen, sel, t1w, late);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule